// File: doc/BRIEF.md
# Bit-Exact Relaxing Prefix-Sum Engine

The engine turns a short vector of small floating-point values into its running sums. Every output word is bit-identical to what a plain left-to-right accumulation with the same adder would produce. It does not trust the tree. It first builds a fast parallel-prefix estimate with a log-depth adder network. It then checks every position against its predecessor plus its own input. Whenever a check fails, it prefix-sums the differences, folds them back into the estimate and checks again. This repeats until every position agrees.

Values use an 8-bit minifloat. Bit 7 is the sign, bits 6:3 are a biased exponent (bias 7) and bits 2:0 are the fraction below an implied leading one. An exponent field of zero means zero. The host writes the vector word by word through a load port and pulses start. It waits for a one-cycle done pulse and then reads any position through an indexed read port. An iteration counter shows how many induction checks the last run needed. An overrun flag reports a run that hit the iteration ceiling.

Top module: `relax_prefix_engine`

## Requirements
- R1: The adder forms the exact sum of two values and truncates it toward zero to 3 fraction bits. An operand whose exponent field is 0 counts as zero. A sum of magnitude below 2^-6, or an exact cancellation, gives 8'h00, so +0 plus −0 is +0. A magnitude of 512 or above gives the largest finite value with the sum's sign (exponent 4'hF, fraction 3'h7).
- R2: While the engine is idle, a cycle with ld_valid high writes ld_data into vector slot ld_idx. While busy, ld_valid is ignored, so a later run over the same vector still returns the original sums.
- R3: A start pulse while idle raises busy on the next cycle. The engine then forms the parallel-prefix estimate of the loaded vector.
- R4: When a run ends without overrun, rd_data at position i equals s_i, where s_{-1} = 8'h00 and s_i = add(s_{i-1}, x_i) under R1.
- R5: A check at position i compares add(estimate_{i-1}, x_i) with estimate_i. Position 0 uses 8'h00 as its predecessor. The check passes only when the two words are exactly equal. The run ends when all positions pass, and any correction computed alongside that check is dropped. A vector whose estimate is already exact (for example all zeros, or a single nonzero word at position 0) ends after exactly 1 check.
- R6: done is high for exactly one cycle, and busy is low in that same cycle. While idle, rd_data shows the stored result of position rd_idx and iter_cnt holds still.
- R7: After a failed check, the earliest failing position takes its check sum directly. Every other position adds the prefix sum of the differences (check sum minus estimate). A run of N=8 positions therefore needs between 1 and N+1 checks.
- R8: iter_cnt counts the checks of the current run. If a check fails when iter_cnt equals ITER_MAX, the run stops: done pulses and overrun rises in that same cycle, and overrun stays high until the next start.
- R9: After reset, busy, done, overrun and iter_cnt are 0 and every stored result reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Write strobe for one vector word |
| ld_idx | input | $clog2(N) | Slot written by the load |
| ld_data | input | 1+EW+MW | Minifloat word to store |
| start | input | 1 | Begin a run over the stored vector |
| rd_idx | input | $clog2(N) | Result position to read |
| rd_data | output | 1+EW+MW | Running sum at rd_idx |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| iter_cnt | output | $clog2(ITER_MAX+1) | Checks made in the current or last run |
| overrun | output | 1 | Last run hit the check ceiling |

## Verification
The bench aims at large-magnitude cancellation, where the tree and the sequential order truly disagree. A design with the wrong sign on the difference, or without the earliest-position override, would settle on the wrong sum or run until the ceiling. Saturating and underflowing sums, and the noncanonical zero at position 0, expose an adder that wraps, keeps a negative zero or reads a zero-exponent word as a number. A second instance with a ceiling of one check must raise overrun on a vector that needs correction, while exact vectors must finish after one check. A load attempted mid-run, followed by a rerun without reloading, shows whether a busy engine wrongly accepts writes.

// File: rtl/relax_pkg.sv
// Shared types for the relaxing prefix-sum engine.
// Assumes: nothing beyond standard SystemVerilog.
package relax_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PFX  = 2'd1,
        ST_CHK  = 2'd2,
        ST_UPD  = 2'd3
    } relax_state_e;
endpackage

// File: rtl/mfa_adder.sv
// Combinational minifloat adder: sign | EW-bit biased exponent | MW-bit fraction.
// Forms the exact aligned sum in a wide field, truncates toward zero,
// flushes underflow and exact cancellation to +0, saturates overflow.
// Assumes: an exponent field of zero encodes zero; no infinities or NaNs.
module mfa_adder #(
    parameter int EW = 4,
    parameter int MW = 3
) (
    input  logic [EW+MW:0] a,
    input  logic [EW+MW:0] b,
    output logic [EW+MW:0] y
);
    localparam int W    = 1 + EW + MW;
    localparam int GD   = 2 ** EW;
    localparam int FW   = MW + 1 + GD;
    localparam int SW   = FW + 1;
    localparam int EMAX = 2 ** EW - 1;

    logic [EW-1:0] ea, eb, e_big, e_sml, dsh;
    logic          za, zb, a_big, s_big, same_sg;
    logic [MW-1:0] m_big, m_sml, m_out;
    logic [SW-1:0] f_big, f_sml, sum;
    int            pos, er, shv;

    // Align, add or subtract exactly, normalise and pack the result.
    always_comb begin
        ea      = a[W-2:MW];
        eb      = b[W-2:MW];
        za      = (ea == '0);
        zb      = (eb == '0);
        a_big   = (a[W-2:0] >= b[W-2:0]);
        e_big   = a_big ? ea : eb;
        e_sml   = a_big ? eb : ea;
        m_big   = a_big ? a[MW-1:0] : b[MW-1:0];
        m_sml   = a_big ? b[MW-1:0] : a[MW-1:0];
        s_big   = a_big ? a[W-1] : b[W-1];
        same_sg = (a[W-1] == b[W-1]);
        dsh     = e_big - e_sml;
        f_big   = {1'b0, 1'b1, m_big, {GD{1'b0}}};
        f_sml   = {1'b0, 1'b1, m_sml, {GD{1'b0}}} >> dsh;
        sum     = same_sg ? (f_big + f_sml) : (f_big - f_sml);
        pos     = 0;
        for (int k = 0; k < SW; k++) begin
            if (sum[k]) pos = k;
        end
        er    = int'(e_big) + pos - (FW - 1);
        shv   = (pos >= MW) ? (pos - MW) : 0;
        m_out = MW'(sum >> shv);
        if (za && zb)          y = '0;
        else if (za)           y = b;
        else if (zb)           y = a;
        else if (sum == '0)    y = '0;
        else if (er > EMAX)    y = {s_big, {EW{1'b1}}, {MW{1'b1}}};
        else if (er < 1)       y = '0;
        else                   y = {s_big, EW'(er), m_out};
    end
endmodule

// File: rtl/skl_prefix_tree.sv
// Sklansky parallel-prefix network of minifloat adders, log2(N) levels.
// At level l, every position with bit l set adds in the last word of the
// lower half of its 2^(l+1) block; all other positions pass through.
// Assumes: N is a power of two, at least 2.
module skl_prefix_tree #(
    parameter int N  = 8,
    parameter int EW = 4,
    parameter int MW = 3
) (
    input  logic [N-1:0][EW+MW:0] x,
    output logic [N-1:0][EW+MW:0] y
);
    localparam int W  = 1 + EW + MW;
    localparam int LG = $clog2(N);

    logic [W-1:0] st [0:LG][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign st[0][i] = x[i];
        assign y[i]     = st[LG][i];
    end

    for (genvar l = 0; l < LG; l++) begin : g_lvl
        for (genvar i = 0; i < N; i++) begin : g_pos
            if (((i >> l) & 1) == 1) begin : g_add
                localparam int PJ = i - (i % (1 << l)) - 1;
                mfa_adder #(.EW(EW), .MW(MW)) u_add (
                    .a(st[l][PJ]),
                    .b(st[l][i]),
                    .y(st[l+1][i])
                );
            end else begin : g_pass
                assign st[l+1][i] = st[l][i];
            end
        end
    end
endmodule

// File: rtl/induct_lane.sv
// One position of the induction check and update.
// spec = pred + xin; err = spec - pcur; mis flags spec != pcur;
// upd is spec when this is the leading failing position, else pcur + epfx.
// Assumes: pred is +0 for position 0, and pcur is unchanged between check and update.
module induct_lane #(
    parameter int EW = 4,
    parameter int MW = 3
) (
    input  logic [EW+MW:0] pred,
    input  logic [EW+MW:0] xin,
    input  logic [EW+MW:0] pcur,
    input  logic [EW+MW:0] epfx,
    input  logic           take,
    output logic [EW+MW:0] err,
    output logic           mis,
    output logic [EW+MW:0] upd
);
    localparam int W = 1 + EW + MW;

    logic [W-1:0] spec, pneg, corr;

    assign pneg = {~pcur[W-1], pcur[W-2:0]};

    mfa_adder #(.EW(EW), .MW(MW)) u_spec (.a(pred), .b(xin),  .y(spec));
    mfa_adder #(.EW(EW), .MW(MW)) u_err  (.a(spec), .b(pneg), .y(err));
    mfa_adder #(.EW(EW), .MW(MW)) u_corr (.a(pcur), .b(epfx), .y(corr));

    // Flag the mismatch and choose the next estimate word.
    always_comb begin
        mis = (spec != pcur);
        upd = take ? spec : corr;
    end
endmodule

// File: rtl/relax_prefix_engine.sv
// Top: loads a vector, forms a prefix estimate and relaxes it until every
// induction check passes, which makes it equal to the sequential running sums.
// Each iteration takes a check cycle and an update cycle. The update cycle tests
// the registered mismatch vector while the correction is computed in parallel,
// and throws the correction away when the check was clean.
// Assumes: synchronous active-low reset; N is a power of two.
module relax_prefix_engine #(
    parameter int N        = 8,
    parameter int EW       = 4,
    parameter int MW       = 3,
    parameter int ITER_MAX = N + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_valid,
    input  logic [$clog2(N)-1:0]            ld_idx,
    input  logic [EW+MW:0]                  ld_data,
    input  logic                            start,
    input  logic [$clog2(N)-1:0]            rd_idx,
    output logic [EW+MW:0]                  rd_data,
    output logic                            busy,
    output logic                            done,
    output logic [$clog2(ITER_MAX+1)-1:0]   iter_cnt,
    output logic                            overrun
);
    import relax_pkg::*;

    localparam int W  = 1 + EW + MW;
    localparam int CW = $clog2(ITER_MAX + 1);

    relax_state_e         state;
    logic [N-1:0][W-1:0]  in_q, p_q, err_q;
    logic [N-1:0][W-1:0]  tree_in, tree_out, err_v, upd_v;
    logic [N-1:0]         mis_q, mis_v, lead;

    assign busy    = (state != ST_IDLE);
    assign rd_data = p_q[rd_idx];
    assign tree_in = (state == ST_PFX) ? in_q : err_q;
    assign lead    = mis_q & (~mis_q + N'(1));

    skl_prefix_tree #(.N(N), .EW(EW), .MW(MW)) u_tree (
        .x(tree_in),
        .y(tree_out)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [W-1:0] pred;
        if (i == 0) begin : g_first
            assign pred = '0;
        end else begin : g_rest
            assign pred = p_q[i-1];
        end
        induct_lane #(.EW(EW), .MW(MW)) u_lane (
            .pred(pred),
            .xin (in_q[i]),
            .pcur(p_q[i]),
            .epfx(tree_out[i]),
            .take(lead[i]),
            .err (err_v[i]),
            .mis (mis_v[i]),
            .upd (upd_v[i])
        );
    end

    // Vector store: written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else if (ld_valid && state == ST_IDLE) begin
            in_q[ld_idx] <= ld_data;
        end
    end

    // Sequencer: prefix, then alternating check and update until clean or ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            p_q      <= '0;
            err_q    <= '0;
            mis_q    <= '0;
            iter_cnt <= '0;
            overrun  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_PFX;
                        iter_cnt <= '0;
                        overrun  <= 1'b0;
                    end
                end
                ST_PFX: begin
                    p_q   <= tree_out;
                    state <= ST_CHK;
                end
                ST_CHK: begin
                    err_q    <= err_v;
                    mis_q    <= mis_v;
                    iter_cnt <= iter_cnt + CW'(1);
                    state    <= ST_UPD;
                end
                ST_UPD: begin
                    if (mis_q == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (iter_cnt == CW'(ITER_MAX)) begin
                        overrun <= 1'b1;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        p_q   <= upd_v;
                        state <= ST_CHK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/relax_prefix_chk.sv
// Property checker for the relaxing prefix-sum engine, bound to the top.
// Assumes: the same parameter values as the bound instance.
module relax_prefix_chk #(
    parameter int ITER_MAX = 9
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic                          busy,
    input logic                          done,
    input logic                          overrun,
    input logic [$clog2(ITER_MAX+1)-1:0] iter_cnt
);
    localparam int CW = $clog2(ITER_MAX + 1);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                          // R6
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                               // R3
    AST_ITER_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        iter_cnt <= CW'(ITER_MAX));                               // R8
    AST_OVERRUN_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> done);                                 // R8
    AST_IDLE_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(iter_cnt));                 // R6
endmodule

bind relax_prefix_engine relax_prefix_chk #(.ITER_MAX(ITER_MAX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .overrun (overrun),
    .iter_cnt(iter_cnt)
);

// File: tb/sim_relax_prefix_engine.sv
// Bench: directed corner vectors plus seeded random vectors, checked against
// running sums computed with real arithmetic and the minifloat truncation rule.
module sim_relax_prefix_engine;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_valid = 1'b0;
    logic [2:0] ld_idx = '0;
    logic [7:0] ld_data = '0;
    logic       start = 1'b0;
    logic [2:0] rd_idx = '0;
    logic [7:0] rd_data, rd_data1;
    logic       busy, done, overrun, busy1, done1, overrun1;
    logic [3:0] iter_cnt;
    logic [0:0] iter_cnt1;

    int total = 0;
    int bad = 0;
    logic [7:0] vec [N];
    logic [7:0] expv [N];

    always #5 clk = ~clk;

    relax_prefix_engine u0 (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .start(start), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .done(done), .iter_cnt(iter_cnt), .overrun(overrun)
    );

    relax_prefix_engine #(.ITER_MAX(1)) u1 (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .start(start), .rd_idx(rd_idx), .rd_data(rd_data1),
        .busy(busy1), .done(done1), .iter_cnt(iter_cnt1), .overrun(overrun1)
    );

    function automatic real pw2(int e);
        real r = 1.0;
        if (e >= 0) for (int k = 0; k < e; k++) r = r * 2.0;
        else        for (int k = 0; k < -e; k++) r = r / 2.0;
        return r;
    endfunction

    function automatic real dec(logic [7:0] v);
        real m;
        if (v[6:3] == 4'd0) return 0.0;
        m = (1.0 + real'(v[2:0]) / 8.0) * pw2(int'(v[6:3]) - 7);
        return v[7] ? -m : m;
    endfunction

    function automatic logic [7:0] enc(real r);
        real m, fr;
        logic s;
        if (r == 0.0) return 8'h00;
        s = (r < 0.0);
        m = s ? -r : r;
        if (m >= 512.0) return {s, 7'h7F};
        for (int e = 15; e >= 1; e--) begin
            if (m >= pw2(e - 7)) begin
                fr = m / pw2(e - 7);
                return {s, 4'(e), 3'($rtoi((fr - 1.0) * 8.0))};
            end
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] ref_add(logic [7:0] a, logic [7:0] b);
        return enc(dec(a) + dec(b));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp_v);
        end
    endtask

    task automatic load_vec();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_idx = 3'(i); ld_data = vec[i];
        end
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic compute_exp();
        logic [7:0] acc = 8'h00;
        for (int i = 0; i < N; i++) begin
            acc = ref_add(acc, vec[i]);
            expv[i] = acc;
        end
    endtask

    // Starts a run; optionally attempts a write during busy (must be ignored).
    task automatic run_and_check(bit poke);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R3 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            ld_valid = 1'b1; ld_idx = 3'd0; ld_data = 8'h7F;
            @(negedge clk); ld_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        check("R6 busy low with done", 32'(busy), 32'd0);
        check("R7 check count in range", 32'((iter_cnt >= 1) && (iter_cnt <= N + 1)), 32'd1);
        check("R8 no overrun at default ceiling", 32'(overrun), 32'd0);
        for (int i = 0; i < N; i++) begin
            rd_idx = 3'(i); #1;
            check($sformatf("R4 pos %0d", i), 32'(rd_data), 32'(expv[i]));
        end
        @(negedge clk);
        check("R6 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 busy", 32'(busy), 32'd0);
        check("R9 done", 32'(done), 32'd0);
        check("R9 overrun", 32'(overrun), 32'd0);
        check("R9 iter", 32'(iter_cnt), 32'd0);
        rd_idx = 3'd5; #1;
        check("R9 result word", 32'(rd_data), 32'd0);

        // R5: all zeros, exact after one check
        for (int i = 0; i < N; i++) vec[i] = 8'h00;
        compute_exp(); load_vec(); run_and_check(0);
        check("R5 zeros take one check", 32'(iter_cnt), 32'd1);
        check("R8 no overrun when exact", 32'(overrun1), 32'd0);

        // R5: single nonzero word at position 0
        vec[0] = 8'h50;
        compute_exp(); load_vec(); run_and_check(0);
        check("R5 single word one check", 32'(iter_cnt), 32'd1);

        // R1 R7 R8: large cancellation the tree gets wrong
        vec[0] = 8'h68; vec[1] = 8'h38; vec[2] = 8'hE8; vec[3] = 8'hB8;
        vec[4] = 8'h68; vec[5] = 8'h30; vec[6] = 8'hE8; vec[7] = 8'hB0;
        compute_exp(); load_vec(); run_and_check(0);
        check("R8 overrun at ceiling one", 32'(overrun1), 32'd1);
        check("R8 ceiling instance count", 32'(iter_cnt1), 32'd1);
        check("R7 needed more than one check", 32'(iter_cnt > 1), 32'd1);

        // R1: saturation, signed cancellation and noncanonical zero at position 0
        vec[0] = 8'h05; vec[1] = 8'h7F; vec[2] = 8'h7F; vec[3] = 8'hFF;
        vec[4] = 8'h08; vec[5] = 8'h88; vec[6] = 8'h09; vec[7] = 8'h88;
        compute_exp(); load_vec(); run_and_check(0);

        // R2: write attempted while busy, then rerun without reloading
        vec[0] = 8'h40; vec[1] = 8'h21; vec[2] = 8'hC2; vec[3] = 8'h13;
        vec[4] = 8'h44; vec[5] = 8'hA5; vec[6] = 8'h46; vec[7] = 8'hC7;
        compute_exp(); load_vec(); run_and_check(1);
        run_and_check(0);

        // R4: seeded random vectors with wide and narrow ranges
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < N; i++) begin
                logic [31:0] r = $urandom;
                if (r[3:0] == 4'd0) vec[i] = 8'h00;
                else if (t % 2 == 0) vec[i] = {r[4], 4'(1 + (r[11:8] % 15)), r[7:5]};
                else vec[i] = {r[4], 4'(8 + (r[9:8])), r[7:5]};
            end
            compute_exp(); load_vec(); run_and_check(0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule